// File: doc/BRIEF.md
# Serial Receive Queue with Trigger and Idle Detection

This block buffers characters that a serial receiver has already deserialized. Each character is stored with three error flags: parity, framing and break. Software reads the characters in arrival order. An 8-bit control write port sets the operating state of the block, empties the queue and selects an interrupt threshold. That port is a single write-only register with no stored flush bits. When the companion transmit queue has to be emptied, the block produces a one-cycle pulse for it.

The block has two interrupt conditions:
- The availability condition rises once the fill level reaches the selected threshold.
- The idle condition rises when characters are waiting and no character has entered or left the queue for a fixed number of character periods. The receiver supplies one `char_tick` pulse per character period.

The block also provides these status outputs:
- A data-ready flag.
- A sticky overrun flag.
- An aggregate error flag that covers every character still held in the queue.

Top module: `rxq_trig`

## Requirements
- R1: The queue holds up to DEPTH (default 16) entries and returns them in arrival order. The head outputs show the oldest entry, and `fill_level` gives the number of entries held.
- R2: A push and a pop in the same cycle both take effect, even when the queue is full, and no overrun is raised. A pop while the queue is empty is ignored.
- R3: The enable state is control bit 0. A write in which bit 0 differs from the current enable state empties the queue and pulses `tx_flush` in the next cycle. While the block is disabled, incoming characters are ignored.
- R4: Writing 1 to control bit 1 empties the queue, and the bit is not stored. Writing 1 to bit 2 pulses `tx_flush` for one cycle and leaves the queue contents untouched. When a flush falls in the same cycle as a push or a pop, the flush wins and the push or pop has no effect.
- R5: Control bits 7:6 select the threshold: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14. `rx_avail` is high exactly when `fill_level` is at or above the threshold.
- R6: A push to a full queue that is not being popped in the same cycle is dropped and sets `overrun`. A status read clears `overrun`, unless a new overrun occurs in that same cycle.
- R7: `any_err` is high exactly when at least one held entry has its parity, framing or break flag set.
- R8: `rx_timeout` rises when the queue is not empty and four `char_tick` pulses pass with no push and no pop. It is cleared by a push, a pop or a flush.
- R9: After reset the queue is empty and the block is disabled. The threshold select is 00 and all flags are low.
- R10: `data_ready` is high exactly when `fill_level` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_push | input | 1 | Receiver delivers a character |
| rx_char | input | 8 | Received character |
| rx_perr | input | 1 | Parity error for the delivered character |
| rx_ferr | input | 1 | Framing error for the delivered character |
| rx_brk | input | 1 | Break seen for the delivered character |
| buf_pop | input | 1 | Read of the receive buffer; removes the head entry |
| stat_rd | input | 1 | Status read; clears overrun |
| char_tick | input | 1 | One pulse per character period |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 8 | Control register write value |
| head_char | output | 8 | Character at the head of the queue |
| head_perr | output | 1 | Parity flag of the head entry |
| head_ferr | output | 1 | Framing flag of the head entry |
| head_brk | output | 1 | Break flag of the head entry |
| fill_level | output | 5 | Number of held entries |
| data_ready | output | 1 | Queue is not empty |
| overrun | output | 1 | Sticky overrun flag |
| any_err | output | 1 | Some held entry carries an error flag |
| rx_avail | output | 1 | Fill level at or above the threshold |
| rx_timeout | output | 1 | Idle condition with characters waiting |
| tx_flush | output | 1 | One-cycle pulse that empties the transmit queue |

## Verification
The collision that matters most is a character arriving in the same cycle as a buffer read while the queue is full. It is provoked by filling the queue and then holding push and pop high together for many cycles. It is judged by the fill level staying at 16, the head advancing, and overrun staying low. A second collision is a control write that flushes in the same cycle as a push or a pop. Random control writes are mixed into heavy traffic to provoke it, and a behavioural queue model that discards both operations judges every cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int CHAR_W = 8;
    localparam int CTL_W  = 8;

    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_RXCLR_BIT = 1;
    localparam int CTL_TXCLR_BIT = 2;
    localparam int CTL_TRIG_LO   = 6;

    localparam int TRIG_L0 = 1;
    localparam int TRIG_L1 = 4;
    localparam int TRIG_L2 = 8;
    localparam int TRIG_L3 = 14;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_FOUR     = 2'b01,
        TRIG_EIGHT    = 2'b10,
        TRIG_FOURTEEN = 2'b11
    } trig_sel_e;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] ch;
    } rxq_entry_t;

    function automatic int trig_level(trig_sel_e s);
        case (s)
            TRIG_ONE:   return TRIG_L0;
            TRIG_FOUR:  return TRIG_L1;
            TRIG_EIGHT: return TRIG_L2;
            default:    return TRIG_L3;
        endcase
    endfunction

    function automatic logic entry_bad(rxq_entry_t e);
        return e.perr | e.ferr | e.brk;
    endfunction
endpackage

// File: rtl/rxq_ctl.sv
module rxq_ctl
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output logic             en,
    output trig_sel_e        trig,
    output logic             rx_flush,
    output logic             tx_flush
);
    logic      en_q;
    trig_sel_e trig_q;
    logic      txf_q;
    logic      en_flip;

    always_comb begin
        en_flip  = wr && (wdata[CTL_EN_BIT] != en_q);
        rx_flush = en_flip || (wr && wdata[CTL_RXCLR_BIT]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            trig_q <= TRIG_ONE;
            txf_q  <= 1'b0;
        end else begin
            txf_q <= en_flip || (wr && wdata[CTL_TXCLR_BIT]);
            if (wr) begin
                en_q   <= wdata[CTL_EN_BIT];
                trig_q <= trig_sel_e'(wdata[CTL_TRIG_LO +: 2]);
            end
        end
    end

    assign en       = en_q;
    assign trig     = trig_q;
    assign tx_flush = txf_q;

    assert_txclr_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata[CTL_TXCLR_BIT]) |=> tx_flush);
    assert_enflip_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && (wdata[CTL_EN_BIT] != en)) |=> tx_flush);
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push_req,
    input  rxq_entry_t       push_entry,
    input  logic             pop_req,
    output rxq_entry_t       head,
    output logic [CNT_W-1:0] count,
    output logic             push_ok,
    output logic             pop_ok
);
    rxq_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        pop_ok  = !flush && pop_req && (cnt != '0);
        push_ok = !flush && push_req && ((cnt != CNT_W'(DEPTH)) || pop_ok);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_entry;
    end

    assign head  = mem[rd_ptr];
    assign count = cnt;

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    assert_level_step_R2: assert property (@(posedge clk) disable iff (rst)
        (push_ok && !pop_ok) |=> (count == $past(count) + 1'b1));
    assert_flush_empty_R4: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));
endmodule

// File: rtl/rxq_idle.sv
module rxq_idle #(
    parameter int TO_CHARS = 4,
    localparam int IC_W = $clog2(TO_CHARS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic nonempty,
    input  logic tick,
    output logic timeout
);
    logic [IC_W-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst || clear || !nonempty) begin
            idle_cnt <= '0;
        end else if (tick && (idle_cnt != IC_W'(TO_CHARS))) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign timeout = (idle_cnt == IC_W'(TO_CHARS));

    assert_timeout_clear_R8: assert property (@(posedge clk) disable iff (rst)
        clear |=> !timeout);
endmodule

// File: rtl/rxq_trig.sv
module rxq_trig
    import rxq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int TO_CHARS = 4,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_push,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    input  logic              buf_pop,
    input  logic              stat_rd,
    input  logic              char_tick,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_data,
    output logic [CHAR_W-1:0] head_char,
    output logic              head_perr,
    output logic              head_ferr,
    output logic              head_brk,
    output logic [CNT_W-1:0]  fill_level,
    output logic              data_ready,
    output logic              overrun,
    output logic              any_err,
    output logic              rx_avail,
    output logic              rx_timeout,
    output logic              tx_flush
);
    logic       en;
    trig_sel_e  trig;
    logic       rx_flush;
    logic       push_req;
    logic       push_ok;
    logic       pop_ok;
    rxq_entry_t in_entry;
    rxq_entry_t head;
    logic       ovf;
    logic       ovr_q;
    logic [CNT_W-1:0] err_cnt;

    rxq_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .wr       (ctl_wr),
        .wdata    (ctl_data),
        .en       (en),
        .trig     (trig),
        .rx_flush (rx_flush),
        .tx_flush (tx_flush)
    );

    always_comb begin
        in_entry.ch   = rx_char;
        in_entry.perr = rx_perr;
        in_entry.ferr = rx_ferr;
        in_entry.brk  = rx_brk;
        push_req      = rx_push && en;
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .flush      (rx_flush),
        .push_req   (push_req),
        .push_entry (in_entry),
        .pop_req    (buf_pop),
        .head       (head),
        .count      (fill_level),
        .push_ok    (push_ok),
        .pop_ok     (pop_ok)
    );

    rxq_idle #(.TO_CHARS(TO_CHARS)) u_idle (
        .clk      (clk),
        .rst      (rst),
        .clear    (push_ok || pop_ok || rx_flush),
        .nonempty (fill_level != '0),
        .tick     (char_tick),
        .timeout  (rx_timeout)
    );

    assign ovf = push_req && !push_ok && !rx_flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q <= 1'b0;
        end else if (ovf) begin
            ovr_q <= 1'b1;
        end else if (stat_rd) begin
            ovr_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || rx_flush) begin
            err_cnt <= '0;
        end else begin
            case ({push_ok && entry_bad(in_entry), pop_ok && entry_bad(head)})
                2'b10:   err_cnt <= err_cnt + 1'b1;
                2'b01:   err_cnt <= err_cnt - 1'b1;
                default: err_cnt <= err_cnt;
            endcase
        end
    end

    always_comb begin
        head_char  = head.ch;
        head_perr  = head.perr;
        head_ferr  = head.ferr;
        head_brk   = head.brk;
        data_ready = (fill_level != '0);
        overrun    = ovr_q;
        any_err    = (err_cnt != '0);
        rx_avail   = (int'(fill_level) >= trig_level(trig));
    end

    assert_overrun_set_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_push && en && (fill_level == CNT_W'(DEPTH)) && !buf_pop && !rx_flush) |=> overrun);
    assert_err_empty_R7: assert property (@(posedge clk) disable iff (rst)
        (fill_level == '0) |-> !any_err);
    assert_disabled_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!en && !ctl_wr && !buf_pop) |=> $stable(fill_level));
endmodule

// File: tb/rxq_trig_test.sv
module rxq_trig_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       rx_push, rx_perr, rx_ferr, rx_brk;
    logic [7:0] rx_char;
    logic       buf_pop, stat_rd, char_tick, ctl_wr;
    logic [7:0] ctl_data;
    logic [7:0] head_char;
    logic       head_perr, head_ferr, head_brk;
    logic [4:0] fill_level;
    logic       data_ready, overrun, any_err, rx_avail, rx_timeout, tx_flush;

    always #2 clk = ~clk;

    rxq_trig uut (
        .clk(clk), .rst(rst), .rx_push(rx_push), .rx_char(rx_char),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
        .buf_pop(buf_pop), .stat_rd(stat_rd), .char_tick(char_tick),
        .ctl_wr(ctl_wr), .ctl_data(ctl_data),
        .head_char(head_char), .head_perr(head_perr), .head_ferr(head_ferr),
        .head_brk(head_brk), .fill_level(fill_level), .data_ready(data_ready),
        .overrun(overrun), .any_err(any_err), .rx_avail(rx_avail),
        .rx_timeout(rx_timeout), .tx_flush(tx_flush)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    armed    = 0;
    bit    finished = 0;
    string lvl_tag  = "R1";

    // behavioural reference
    bit [10:0] mq[$];
    bit        m_en, m_ovr, m_txf;
    int        m_trig, m_idle;

    always @(posedge clk) begin
        bit flush, did_pop, did_push, ovf;
        if (rst) begin
            mq.delete(); m_en = 0; m_ovr = 0; m_txf = 0; m_trig = 0; m_idle = 0;
        end else begin
            flush = 0; ovf = 0; m_txf = 0;
            if (ctl_wr) begin
                if (ctl_data[0] != m_en) begin flush = 1; m_txf = 1; end
                if (ctl_data[1]) flush = 1;
                if (ctl_data[2]) m_txf = 1;
                m_en   = ctl_data[0];
                m_trig = int'(ctl_data[7:6]);
            end
            if (flush) begin
                mq.delete(); m_idle = 0;
            end else begin
                did_pop  = buf_pop && mq.size() > 0;
                did_push = rx_push && m_en && (mq.size() < 16 || did_pop);
                ovf      = rx_push && m_en && mq.size() == 16 && !did_pop;
                if (did_push || did_pop) m_idle = 0;
                else if (mq.size() == 0) m_idle = 0;
                else if (char_tick && m_idle < 4) m_idle++;
                if (did_pop) void'(mq.pop_front());
                if (did_push) mq.push_back({rx_brk, rx_ferr, rx_perr, rx_char});
            end
            if (ovf) m_ovr = 1;
            else if (stat_rd) m_ovr = 0;
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !finished) begin
            int thr, errs;
            thr  = (m_trig == 0) ? 1 : (m_trig == 1) ? 4 : (m_trig == 2) ? 8 : 14;
            errs = 0;
            foreach (mq[i]) if (mq[i][10:8] != 0) errs++;
            chk(lvl_tag, "fill_level", int'(fill_level), mq.size());
            chk("R10", "data_ready", int'(data_ready), int'(mq.size() != 0));
            if (mq.size() != 0)
                chk("R1", "head", int'({head_brk, head_ferr, head_perr, head_char}), int'(mq[0]));
            chk("R5", "rx_avail", int'(rx_avail), int'(mq.size() >= thr));
            chk("R6", "overrun", int'(overrun), int'(m_ovr));
            chk("R7", "any_err", int'(any_err), int'(errs != 0));
            chk("R8", "rx_timeout", int'(rx_timeout), int'(m_idle == 4));
            chk("R3", "tx_flush", int'(tx_flush), int'(m_txf));
        end
    end

    task automatic idle_in();
        rx_push = 0; buf_pop = 0; stat_rd = 0; char_tick = 0; ctl_wr = 0; ctl_data = 0;
        rx_perr = 0; rx_ferr = 0; rx_brk = 0; rx_char = 0;
    endtask

    task automatic step(int p_push, int p_pop, int p_tick, int p_stat);
        @(negedge clk);
        idle_in();
        rx_push   = ($urandom_range(99) < p_push);
        buf_pop   = ($urandom_range(99) < p_pop);
        char_tick = ($urandom_range(99) < p_tick);
        stat_rd   = ($urandom_range(99) < p_stat);
        rx_char   = 8'($urandom);
        rx_perr   = ($urandom_range(99) < 10);
        rx_ferr   = ($urandom_range(99) < 10);
        rx_brk    = ($urandom_range(99) < 5);
    endtask

    task automatic run(int n, int p_push, int p_pop, int p_tick, int p_stat);
        for (int i = 0; i < n; i++) step(p_push, p_pop, p_tick, p_stat);
    endtask

    task automatic wr_ctl(logic [7:0] v, bit with_traffic);
        step(with_traffic ? 100 : 0, with_traffic ? 100 : 0, 0, 0);
        ctl_wr = 1; ctl_data = v;
    endtask

    initial begin
        idle_in();
        rst = 1;
        @(posedge clk);
        armed = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9: reset state seen at the ports
        chk("R9", "reset fill_level", int'(fill_level), 0);
        chk("R9", "reset flags", int'({overrun, any_err, rx_avail, rx_timeout, tx_flush, data_ready}), 0);

        // R3: disabled block ignores characters
        lvl_tag = "R3";
        run(10, 100, 0, 0, 0);
        wr_ctl(8'h01, 0);
        lvl_tag = "R1";
        run(40, 80, 15, 20, 0);          // fill and overrun (R6)
        run(6, 0, 0, 0, 100);            // status reads clear overrun
        lvl_tag = "R2";
        run(30, 100, 100, 0, 0);         // full queue, simultaneous push and pop
        run(20, 0, 100, 0, 0);           // drain, then pops on empty
        lvl_tag = "R1";
        // R5: each threshold
        wr_ctl(8'h41, 0); run(60, 50, 45, 10, 10);
        wr_ctl(8'h81, 0); run(60, 55, 45, 10, 10);
        wr_ctl(8'hC1, 0); run(60, 60, 40, 10, 10);
        wr_ctl(8'h01, 0);
        // R8: idle detection
        run(20, 0, 100, 0, 0);
        run(3, 100, 0, 0, 0);
        run(8, 0, 0, 100, 0);
        run(1, 0, 100, 0, 0);
        run(8, 0, 0, 100, 0);
        run(1, 100, 0, 0, 0);
        run(10, 0, 0, 60, 0);
        // R4: queue flush and transmit flush
        lvl_tag = "R4";
        run(12, 100, 0, 0, 0);
        wr_ctl(8'h03, 1);
        run(8, 100, 0, 0, 0);
        wr_ctl(8'h05, 0);
        run(4, 0, 0, 0, 0);
        // R3: disable flushes, then ignores input, re-enable
        lvl_tag = "R3";
        wr_ctl(8'h00, 1);
        run(20, 100, 30, 30, 0);
        wr_ctl(8'h01, 1);
        run(10, 100, 0, 0, 0);
        // long mixed run with random control writes
        lvl_tag = "R2";
        for (int i = 0; i < 3000; i++) begin
            step(55, 45, 30, 10);
            if ($urandom_range(99) < 3) begin
                ctl_wr   = 1;
                ctl_data = 8'($urandom);
                ctl_data[0] = ($urandom_range(99) < 90);
                if ($urandom_range(99) < 70) ctl_data[2:1] = 2'b00;
            end
        end
        @(negedge clk);
        idle_in();
        @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule